// File: doc/BRIEF.md
# PLL Reset and Clock-Mode Sequencer

This block sits between a software control word and a system PLL plus the chip-wide reset line. Software writes one control word carrying a hold count, a clock-source choice, direct power-down and oscillator-reset controls for the PLL, three clock-domain mode bits, and a start bit. The direct PLL controls take effect on the cycle after the write. The clock-source and mode bits are only staged: they reach the clock multiplexer and the domain logic when a reset sequence finishes.

Setting the start bit runs a reset sequence. Chip reset is asserted and the PLL is held powered down for a span set by the hold count, counted in units of 16 reference cycles. The block then keeps chip reset asserted until the PLL reports lock or a second span of the same length runs out, whichever happens first. When reset is released, the staged settings are applied and the start bit clears. Strap pins are latched during power-on reset and can be read back as status. The PLL itself is modelled only by its lock input and its power-down and reset controls.

All pins are plain level control and status signals. None carries a data stream, so there is no valid/ready handshake and no back-pressure. A write takes effect on the clock edge where `cfg_wr` is sampled high.

Top module: `pll_rst_seq`

## Requirements
- R1: While `por_n` is low and afterwards until the first write: `chip_rst`, `seq_busy`, `pll_pd`, `pll_rst`, `mem_half_rate`, `sync_core`, `sync_io` are 0, `clk_sel_ref` is 1, and `cfg_rdata[14:0]` reads 0.
- R2: `cfg_rdata[16]` and `cfg_rdata[20:17]` hold the values of `strap_stall` and `strap_boot` latched while `por_n` was low. Later changes on the strap pins do not alter them and have no other effect.
- R3: Control word layout: `[7:0]` hold count H, `[8]` clock-source choice (1 = reference clock), `[9]` power-down, `[10]` PLL reset, `[11]` memory half-rate, `[12]` core sync, `[13]` I/O sync, `[14]` start. With no sequence running, a write drives bits 9 and 10 onto `pll_pd` and `pll_rst` from the next cycle.
- R4: The write that starts a sequence clears bits 9 and 10 of the register. While a sequence runs, these bits stay 0 and `pll_rst` is 0.
- R5: After the starting write, `pll_pd` and `chip_rst` are both high for max(16*H, 1) cycles.
- R6: If lock never arrives, `chip_rst` stays high with `pll_pd` low for max(16*H, 1) further cycles, then falls.
- R7: If `pll_lock` is high during a cycle of the lock-wait phase, `chip_rst` falls at the next edge. Lock during the power-down phase is ignored.
- R8: `clk_sel_ref`, `mem_half_rate`, `sync_core` and `sync_io` change only on the edge where `chip_rst` falls. They take bits 8, 11, 12 and 13 of the starting write. Writes without start, and writes during a sequence, leave them unchanged.
- R9: The start bit (`cfg_rdata[14]`) clears on the edge where `chip_rst` falls. A write with the start bit set during a sequence neither restarts nor lengthens it.
- R10: The hold count is taken from the starting write. A new hold count written during the sequence is stored but does not change the running spans.
- R11: `seq_busy` equals `chip_rst` on every cycle, and `cfg_rdata[15]` reads `seq_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 15 | Control word |
| cfg_rdata | output | 21 | Control word readback plus busy and strap status |
| strap_stall | input | 1 | Debug-stall strap pin |
| strap_boot | input | 4 | Boot strap pins |
| pll_lock | input | 1 | PLL lock indication |
| pll_pd | output | 1 | PLL power-down, active high |
| pll_rst | output | 1 | PLL oscillator reset, active high |
| chip_rst | output | 1 | Chip-wide reset, active high |
| seq_busy | output | 1 | Sequence in progress |
| clk_sel_ref | output | 1 | 1 selects the reference clock, 0 the PLL output |
| mem_half_rate | output | 1 | Applied memory half-rate mode |
| sync_core | output | 1 | Applied core synchronous mode |
| sync_io | output | 1 | Applied I/O synchronous mode |

## Verification
The bench measures both phase lengths for hold counts 0, 3 and 255. A design that counts N+1 cycles, or that skips the floor of one cycle for a zero count, shows up as a length that is off by one. Lock is held high from the very start of one sequence: a design that let lock cut the power-down phase short releases reset after one cycle instead of 33. A second start write with a different hold count is sent during a run. It catches a design that restarts the sequence or reloads the span. Mode outputs are read during and after a sequence and after a plain write, which catches settings that leak through before reset is released.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PDN  = 2'd1,
    SEQ_LOCKW = 2'd2
  } seq_st_e;

  typedef struct packed {
    logic ref_sel;
    logic mem_half;
    logic sync_core;
    logic sync_io;
  } mode_t;

  localparam mode_t MODE_POR = '{ref_sel: 1'b1, mem_half: 1'b0, sync_core: 1'b0, sync_io: 1'b0};
endpackage

// File: rtl/pll_ctrl_reg.sv
module pll_ctrl_reg #(
  parameter int HOLD_W = 8,
  parameter int BOOT_W = 4,
  localparam int CW = HOLD_W + 7
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr,
  input  logic [CW-1:0]     wdata,
  input  logic              busy,
  input  logic              done,
  input  logic              strap_stall,
  input  logic [BOOT_W-1:0] strap_boot,
  output logic              trig,
  output logic [CW-1:0]     ctrl_q,
  output logic              stall_q,
  output logic [BOOT_W-1:0] boot_q
);
  localparam int P_BYP  = HOLD_W;
  localparam int P_PD   = HOLD_W + 1;
  localparam int P_PRST = HOLD_W + 2;
  localparam int P_GO   = HOLD_W + 6;

  logic [HOLD_W-1:0] hold_q;
  logic byp_q, pd_q, prst_q, mem_q, sc_q, sio_q, go_q;

  // start is accepted only from idle
  assign trig = wr && wdata[P_GO] && !busy;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hold_q  <= '0;
      byp_q   <= 1'b0;
      pd_q    <= 1'b0;
      prst_q  <= 1'b0;
      mem_q   <= 1'b0;
      sc_q    <= 1'b0;
      sio_q   <= 1'b0;
      go_q    <= 1'b0;
      stall_q <= strap_stall;
      boot_q  <= strap_boot;
    end else begin
      if (wr) begin
        hold_q <= wdata[HOLD_W-1:0];
        byp_q  <= wdata[P_BYP];
        mem_q  <= wdata[P_PRST+1];
        sc_q   <= wdata[P_PRST+2];
        sio_q  <= wdata[P_PRST+3];
        if (busy || trig) begin
          pd_q   <= 1'b0;
          prst_q <= 1'b0;
        end else begin
          pd_q   <= wdata[P_PD];
          prst_q <= wdata[P_PRST];
        end
      end
      if (done) go_q <= 1'b0;
      else if (trig) go_q <= 1'b1;
    end
  end

  assign ctrl_q = {go_q, sio_q, sc_q, mem_q, prst_q, pd_q, byp_q, hold_q};
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int HOLD_W = 8,
  parameter int TICK_LOG2 = 4,
  localparam int CNT_W = HOLD_W + TICK_LOG2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              trig,
  input  logic [HOLD_W-1:0] hold_in,
  input  logic              lock,
  output logic              in_pd,
  output logic              in_rst,
  output logic              done
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q, span_q;
  logic             last;

  assign last   = (cnt_q <= CNT_ONE);
  assign in_pd  = (st_q == SEQ_PDN);
  assign in_rst = (st_q != SEQ_IDLE);
  assign done   = (st_q == SEQ_LOCKW) && (lock || last);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q   <= SEQ_IDLE;
      cnt_q  <= '0;
      span_q <= '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: if (trig) begin
          st_q   <= SEQ_PDN;
          cnt_q  <= {hold_in, {TICK_LOG2{1'b0}}};
          span_q <= {hold_in, {TICK_LOG2{1'b0}}};
        end
        SEQ_PDN: begin
          if (last) begin
            st_q  <= SEQ_LOCKW;
            cnt_q <= span_q;
          end else begin
            cnt_q <= cnt_q - CNT_ONE;
          end
        end
        SEQ_LOCKW: begin
          if (done) st_q <= SEQ_IDLE;
          else cnt_q <= cnt_q - CNT_ONE;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_mode_stage.sv
module pll_mode_stage
  import pll_seq_pkg::*;
(
  input  logic  clk,
  input  logic  por_n,
  input  logic  trig,
  input  logic  done,
  input  mode_t wr_mode,
  output mode_t applied
);
  mode_t pend_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pend_q  <= MODE_POR;
      applied <= MODE_POR;
    end else begin
      if (trig) pend_q <= wr_mode;
      if (done) applied <= pend_q;
    end
  end
endmodule

// File: rtl/pll_rst_seq.sv
module pll_rst_seq
  import pll_seq_pkg::*;
#(
  parameter int HOLD_W = 8,
  parameter int TICK_LOG2 = 4,
  parameter int BOOT_W = 4,
  localparam int CW = HOLD_W + 7,
  localparam int RW = CW + 2 + BOOT_W
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              cfg_wr,
  input  logic [CW-1:0]     cfg_wdata,
  output logic [RW-1:0]     cfg_rdata,
  input  logic              strap_stall,
  input  logic [BOOT_W-1:0] strap_boot,
  input  logic              pll_lock,
  output logic              pll_pd,
  output logic              pll_rst,
  output logic              chip_rst,
  output logic              seq_busy,
  output logic              clk_sel_ref,
  output logic              mem_half_rate,
  output logic              sync_core,
  output logic              sync_io
);
  localparam int P_BYP  = HOLD_W;
  localparam int P_PD   = HOLD_W + 1;
  localparam int P_PRST = HOLD_W + 2;
  localparam int P_MEM  = HOLD_W + 3;
  localparam int P_SC   = HOLD_W + 4;
  localparam int P_SIO  = HOLD_W + 5;

  logic              trig, done, in_pd, in_rst, stall_q;
  logic [CW-1:0]     ctrl_q;
  logic [BOOT_W-1:0] boot_q;
  mode_t             wr_mode, applied;

  pll_ctrl_reg #(.HOLD_W(HOLD_W), .BOOT_W(BOOT_W)) u_reg (
    .clk(clk), .por_n(por_n), .wr(cfg_wr), .wdata(cfg_wdata),
    .busy(in_rst), .done(done), .strap_stall(strap_stall),
    .strap_boot(strap_boot), .trig(trig), .ctrl_q(ctrl_q),
    .stall_q(stall_q), .boot_q(boot_q)
  );

  pll_seq_fsm #(.HOLD_W(HOLD_W), .TICK_LOG2(TICK_LOG2)) u_fsm (
    .clk(clk), .por_n(por_n), .trig(trig),
    .hold_in(cfg_wdata[HOLD_W-1:0]), .lock(pll_lock),
    .in_pd(in_pd), .in_rst(in_rst), .done(done)
  );

  assign wr_mode = '{ref_sel: cfg_wdata[P_BYP], mem_half: cfg_wdata[P_MEM],
                     sync_core: cfg_wdata[P_SC], sync_io: cfg_wdata[P_SIO]};

  pll_mode_stage u_mode (
    .clk(clk), .por_n(por_n), .trig(trig), .done(done),
    .wr_mode(wr_mode), .applied(applied)
  );

  assign pll_pd        = ctrl_q[P_PD] | in_pd;
  assign pll_rst       = ctrl_q[P_PRST];
  assign chip_rst      = in_rst;
  assign seq_busy      = in_rst;
  assign clk_sel_ref   = applied.ref_sel;
  assign mem_half_rate = applied.mem_half;
  assign sync_core     = applied.sync_core;
  assign sync_io       = applied.sync_io;
  assign cfg_rdata     = {boot_q, stall_q, in_rst, ctrl_q};
endmodule

// File: rtl/pll_rst_seq_chk.sv
module pll_rst_seq_chk #(
  parameter int SW = 5
) (
  input logic          clk,
  input logic          por_n,
  input logic          go_bit,
  input logic [SW-1:0] strap_view,
  input logic          pll_lock,
  input logic          pll_pd,
  input logic          pll_rst,
  input logic          chip_rst,
  input logic          seq_busy,
  input logic          clk_sel_ref,
  input logic          mem_half_rate,
  input logic          sync_core,
  input logic          sync_io
);
  // R2
  strap_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    $stable(strap_view));
  // R4
  rst_bit_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    chip_rst |-> !pll_rst);
  // R5
  pd_on_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(chip_rst) |-> pll_pd);
  // R7
  lock_release_chk: assert property (@(posedge clk) disable iff (!por_n)
    (chip_rst && !pll_pd && pll_lock) |=> !chip_rst);
  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!$stable(clk_sel_ref) || !$stable(mem_half_rate) || !$stable(sync_core)
     || !$stable(sync_io)) |-> $fell(chip_rst));
  // R9
  go_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(chip_rst) |-> !go_bit);
  // R11
  busy_match_chk: assert property (@(posedge clk) disable iff (!por_n)
    seq_busy == chip_rst);
endmodule

bind pll_rst_seq pll_rst_seq_chk #(.SW(BOOT_W + 1)) u_chk (
  .clk(clk), .por_n(por_n), .go_bit(cfg_rdata[CW-1]),
  .strap_view(cfg_rdata[RW-1:CW+1]), .pll_lock(pll_lock), .pll_pd(pll_pd),
  .pll_rst(pll_rst), .chip_rst(chip_rst), .seq_busy(seq_busy),
  .clk_sel_ref(clk_sel_ref), .mem_half_rate(mem_half_rate),
  .sync_core(sync_core), .sync_io(sync_io)
);

// File: tb/pll_rst_seq_bench.sv
module pll_rst_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 100000;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [14:0] cfg_wdata = '0;
  logic [20:0] cfg_rdata;
  logic        strap_stall = 1'b1;
  logic [3:0]  strap_boot = 4'b1010;
  logic        pll_lock = 1'b0;
  logic        pll_pd, pll_rst, chip_rst, seq_busy;
  logic        clk_sel_ref, mem_half_rate, sync_core, sync_io;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  pll_rst_seq u_pll_rst_seq (
    .clk(clk), .por_n(por_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .strap_stall(strap_stall), .strap_boot(strap_boot),
    .pll_lock(pll_lock), .pll_pd(pll_pd), .pll_rst(pll_rst),
    .chip_rst(chip_rst), .seq_busy(seq_busy), .clk_sel_ref(clk_sel_ref),
    .mem_half_rate(mem_half_rate), .sync_core(sync_core), .sync_io(sync_io)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      summary();
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] word(int h, bit byp, bit pd, bit prst,
                                       bit mem, bit sc, bit sio, bit go);
    return {go, sio, sc, mem, prst, pd, byp, 8'(h)};
  endfunction

  // called at a negedge, returns at the next negedge
  task automatic wr(logic [14:0] d);
    cfg_wdata = d;
    cfg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // counts samples from the current negedge until chip_rst is low
  task automatic measure(output int pd_n, output int rw_n);
    pd_n = 0;
    rw_n = 0;
    for (int i = 0; i < 20000; i++) begin
      if (!chip_rst) break;
      if (pll_pd) pd_n++;
      else rw_n++;
      if (pll_rst) begin
        n_chk++; n_bad++;
        $display("FAIL R4: actual pll_rst 1 expected 0 during sequence");
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 chip_rst", chip_rst, 0);
    chk("R1 seq_busy", seq_busy, 0);
    chk("R1 pll_pd", pll_pd, 0);
    chk("R1 pll_rst", pll_rst, 0);
    chk("R1 clk_sel_ref", clk_sel_ref, 1);
    chk("R1 modes", {mem_half_rate, sync_core, sync_io}, 0);
    chk("R1 ctrl readback", cfg_rdata[14:0], 0);
  endtask

  task automatic t_straps();
    strap_stall = 1'b0;
    strap_boot = 4'b0101;
    @(negedge clk);
    chk("R2 stall", cfg_rdata[16], 1);
    chk("R2 boot", cfg_rdata[20:17], 4'b1010);
    chk("R2 no effect", {chip_rst, pll_pd, clk_sel_ref}, 3'b001);
  endtask

  task automatic t_direct_bits();
    wr(word(0, 0, 1, 1, 0, 0, 0, 0));
    chk("R3 pll_pd", pll_pd, 1);
    chk("R3 pll_rst", pll_rst, 1);
    chk("R3 no sequence", chip_rst, 0);
    wr(word(0, 0, 0, 0, 0, 0, 0, 0));
    chk("R3 pll_pd off", pll_pd, 0);
  endtask

  task automatic t_timeout(int h, bit pd_in_word);
    int pd_n, rw_n, exp_n;
    exp_n = (h == 0) ? 1 : 16 * h;
    wr(word(h, 1, pd_in_word, pd_in_word, 0, 0, 0, 1));
    chk("R11 busy", seq_busy, 1);
    measure(pd_n, rw_n);
    chk("R5 power-down span", pd_n, exp_n);
    chk("R6 lock-wait span", rw_n, exp_n);
    chk("R9 start cleared", cfg_rdata[14], 0);
    chk("R4 pd/prst bits", cfg_rdata[10:9], 0);
    chk("R4 pll_pd after", pll_pd, 0);
  endtask

  task automatic t_lock_early();
    int pd_n, rw_n;
    pll_lock = 1'b1;
    wr(word(2, 1, 0, 0, 0, 0, 0, 1));
    measure(pd_n, rw_n);
    chk("R7 lock ignored while powered down", pd_n, 32);
    chk("R7 early release", rw_n, 1);
    pll_lock = 1'b0;
  endtask

  task automatic t_retrigger();
    int pd_n, rw_n;
    wr(word(2, 1, 0, 0, 0, 0, 0, 1));
    wr(word(100, 1, 0, 0, 1, 1, 1, 1));
    measure(pd_n, rw_n);
    chk("R10 span kept", pd_n + 1, 32);
    chk("R9 no restart", rw_n, 32);
    chk("R10 new count stored", cfg_rdata[7:0], 100);
    chk("R8 busy write not applied", {mem_half_rate, sync_core, sync_io}, 0);
    @(negedge clk);
    chk("R9 stays idle", chip_rst, 0);
  endtask

  task automatic t_modes();
    int pd_n, rw_n;
    wr(word(1, 0, 0, 0, 1, 1, 0, 1));
    chk("R8 ref kept during sequence", clk_sel_ref, 1);
    chk("R8 modes held during sequence", {mem_half_rate, sync_core, sync_io}, 0);
    measure(pd_n, rw_n);
    chk("R8 clk_sel_ref applied", clk_sel_ref, 0);
    chk("R8 modes applied", {mem_half_rate, sync_core, sync_io}, 3'b110);
    wr(word(1, 1, 0, 0, 0, 0, 1, 0));
    @(negedge clk);
    chk("R8 plain write clk_sel_ref", clk_sel_ref, 0);
    chk("R8 plain write modes", {mem_half_rate, sync_core, sync_io}, 3'b110);
    chk("R11 readback busy", cfg_rdata[15], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    por_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_straps();
    t_direct_bits();
    t_timeout(0, 1'b0);
    t_timeout(3, 1'b1);
    t_timeout(255, 1'b0);
    t_lock_early();
    t_retrigger();
    t_modes();
    summary();
  end
endmodule